// File: doc/BRIEF.md
# Clock Divider Transition Sequencer

This block moves a core clock between the divide ratios 1, 2, 4, 6 and 8 in a safe order. A requester presents a ratio index on a valid/ack handshake; on acceptance the block captures the present value of the clock mode register, decides which intermediate ratio it must pass through, and then issues a timed series of divider-field writes and memory refresh-count updates until the clock runs at the requested ratio.

The ordering depends on the direction of each hop. When the clock gets slower, the refresh interval is shortened for the new ratio before the divider changes. When it gets faster, the divider changes first. Every divider write is followed by a fixed phase-locked-loop settling wait. The one hop from full speed to half speed also waits for the refresh counters to drain, unless the memory is in self-refresh. Jumps between full speed and any ratio slower than half speed are always split into two hops through half speed.

Top module: `div_seq_top`

## Requirements
- R1: Index 0..4 selects divide-by 1, 2, 4, 6, 8. The divider field is bits [2:0] of the mode word, coded 1=000, 2=001, 4=011, 6=010, 8=100. An unknown current field is read as divide-by-1.
- R2: After each divider write, no further divider or refresh write occurs for at least LOCK_CYC (16) cycles.
- R3: A move from divide-by-1 to 4, 6 or 8 is done as a hop to divide-by-2 followed by a hop to the target.
- R4: A move from divide-by-4, 6 or 8 to divide-by-1 is done as a hop to divide-by-2 followed by a hop to divide-by-1.
- R5: A hop to a smaller divisor writes the divider first, waits the lock time, then writes the refresh count.
- R6: A hop to a larger divisor writes the refresh count first and the divider after it.
- R7: On the 1-to-2 hop with self_refresh low, the divider write comes at least CLKS_PER_CNT*(refresh(1)+refresh(2)) cycles after the refresh write. With self_refresh high it follows within 4 cycles.
- R8: A request for the ratio already in the mode field is acknowledged and produces no writes.
- R9: Bits [MODE_W-1:3] of every divider write equal those of cur_mode at acceptance.
- R10: req_ack is never high while busy; a request raised during a sequence waits until it ends.
- R11: An index above 4 gives a one-cycle req_err, no req_ack and no writes.
- R12: The refresh value written for a ratio is REFR_BASE divided by its divisor, rounded down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_index | input | 3 | Requested ratio index |
| req_ack | output | 1 | Request accepted this cycle |
| req_err | output | 1 | Request rejected (bad index) this cycle |
| cur_mode | input | MODE_W | Current clock mode register value |
| self_refresh | input | 1 | Memory is in self-refresh |
| mode_wr | output | 1 | Divider register write strobe |
| mode_wdata | output | MODE_W | Divider register write value |
| refr_wr | output | 1 | Refresh count update strobe |
| refr_val | output | REFR_W | Refresh count value |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench walks the full-speed to slow and slow to full-speed detours, where a design that jumped straight across would write 011, 010 or 100 right after 000. It times the gap after every divider write and around the drain wait, so a short lock wait, a missing drain or a drain applied under self-refresh shows up as an out-of-window gap. Same-ratio and bad-index requests catch stray writes, and a request raised during a sequence catches a design that accepts it early and interleaves writes.

// File: rtl/div_seq_pkg.sv
package div_seq_pkg;

    typedef enum logic [2:0] {
        DV1 = 3'd0,
        DV2 = 3'd1,
        DV4 = 3'd2,
        DV6 = 3'd3,
        DV8 = 3'd4
    } ratio_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PLAN,
        S_REFA,
        S_DRAIN,
        S_WR,
        S_LOCK,
        S_REFB
    } seq_state_e;

    localparam logic [2:0] MAX_INDEX = 3'd4;

    function automatic logic [2:0] code_of(ratio_e r);
        case (r)
            DV1:     return 3'b000;
            DV2:     return 3'b001;
            DV4:     return 3'b011;
            DV6:     return 3'b010;
            DV8:     return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic ratio_e ratio_from_code(logic [2:0] c);
        case (c)
            3'b001:  return DV2;
            3'b011:  return DV4;
            3'b010:  return DV6;
            3'b100:  return DV8;
            default: return DV1;
        endcase
    endfunction

    function automatic int divisor_of(ratio_e r);
        case (r)
            DV1:     return 1;
            DV2:     return 2;
            DV4:     return 4;
            DV6:     return 6;
            DV8:     return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int refr_of(ratio_e r, int base);
        case (r)
            DV1:     return base;
            DV2:     return base / 2;
            DV4:     return base / 4;
            DV6:     return base / 6;
            DV8:     return base / 8;
            default: return base;
        endcase
    endfunction

endpackage

// File: rtl/div_seq_hop.sv
module div_seq_hop
    import div_seq_pkg::*;
(
    input  ratio_e cur,
    input  ratio_e tgt,
    output ratio_e hop,
    output logic   slow,
    output logic   first_step
);
    always_comb begin
        if (cur == DV1 && tgt > DV2)
            hop = DV2;
        else if (cur > DV2 && tgt == DV1)
            hop = DV2;
        else
            hop = tgt;
        slow       = (hop > cur);
        first_step = (cur == DV1) && (hop == DV2);
    end
endmodule

// File: rtl/div_seq_timer.sv
module div_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/div_seq_top.sv
module div_seq_top
    import div_seq_pkg::*;
#(
    parameter int MODE_W       = 16,
    parameter int REFR_W       = 7,
    parameter int LOCK_CYC     = 16,
    parameter int CLKS_PER_CNT = 64,
    parameter int REFR_BASE    = 12,
    parameter int CNT_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_index,
    output logic              req_ack,
    output logic              req_err,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic              self_refresh,
    output logic              mode_wr,
    output logic [MODE_W-1:0] mode_wdata,
    output logic              refr_wr,
    output logic [REFR_W-1:0] refr_val,
    output logic              busy
);
    localparam int HI_W = MODE_W - 3;
    localparam logic [CNT_W-1:0] LOCK_LOAD = CNT_W'(LOCK_CYC - 1);

    seq_state_e      st_q;
    ratio_e          cur_q, tgt_q, hop_q;
    logic            slow_q, drain_q;
    logic [HI_W-1:0] hi_q;

    ratio_e          hop_c;
    logic            slow_c, first_c;
    logic            tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val, drain_len;
    logic            idle, idx_ok;

    div_seq_hop u_hop (
        .cur        (cur_q),
        .tgt        (tgt_q),
        .hop        (hop_c),
        .slow       (slow_c),
        .first_step (first_c)
    );

    div_seq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    assign idle    = (st_q == S_IDLE);
    assign idx_ok  = (req_index <= MAX_INDEX);
    assign req_ack = idle && req_valid && idx_ok;
    assign req_err = idle && req_valid && !idx_ok;
    assign busy    = !idle;

    assign drain_len = CNT_W'(CLKS_PER_CNT
                       * (refr_of(cur_q, REFR_BASE) + refr_of(hop_q, REFR_BASE))
                       * divisor_of(cur_q) - 1);

    assign tmr_load = (st_q == S_WR) || (st_q == S_REFA && drain_q);
    assign tmr_val  = (st_q == S_WR) ? LOCK_LOAD : drain_len;

    assign mode_wr    = (st_q == S_WR);
    assign mode_wdata = {hi_q, code_of(hop_q)};
    assign refr_wr    = (st_q == S_REFA) || (st_q == S_REFB);
    assign refr_val   = REFR_W'(refr_of(hop_q, REFR_BASE));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            cur_q   <= DV1;
            tgt_q   <= DV1;
            hop_q   <= DV1;
            slow_q  <= 1'b0;
            drain_q <= 1'b0;
            hi_q    <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (req_ack) begin
                        cur_q <= ratio_from_code(cur_mode[2:0]);
                        tgt_q <= ratio_e'(req_index);
                        hi_q  <= cur_mode[MODE_W-1:3];
                        st_q  <= S_PLAN;
                    end
                end
                S_PLAN: begin
                    if (cur_q == tgt_q) begin
                        st_q <= S_IDLE;
                    end else begin
                        hop_q   <= hop_c;
                        slow_q  <= slow_c;
                        drain_q <= first_c && !self_refresh;
                        st_q    <= slow_c ? S_REFA : S_WR;
                    end
                end
                S_REFA:  st_q <= drain_q ? S_DRAIN : S_WR;
                S_DRAIN: if (tmr_done) st_q <= S_WR;
                S_WR:    st_q <= S_LOCK;
                S_LOCK: begin
                    if (tmr_done) begin
                        cur_q <= hop_q;
                        st_q  <= slow_q ? S_PLAN : S_REFB;
                    end
                end
                S_REFB:  st_q <= S_PLAN;
                default: st_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/div_seq_chk.sv
module div_seq_chk #(
    parameter int MODE_W   = 16,
    parameter int LOCK_CYC = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ack,
    input logic              req_err,
    input logic [MODE_W-1:0] cur_mode,
    input logic              mode_wr,
    input logic [MODE_W-1:0] mode_wdata,
    input logic              refr_wr,
    input logic              busy
);
    localparam int GW = $clog2(LOCK_CYC + 1);

    logic [GW-1:0]     since_q;
    logic [2:0]        last_code_q;
    logic [MODE_W-4:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q     <= GW'(LOCK_CYC);
            last_code_q <= 3'b000;
            hi_q        <= '0;
        end else begin
            if (mode_wr)
                since_q <= '0;
            else if (since_q < GW'(LOCK_CYC))
                since_q <= since_q + 1'b1;
            if (req_ack) begin
                last_code_q <= cur_mode[2:0];
                hi_q        <= cur_mode[MODE_W-1:3];
            end else if (mode_wr) begin
                last_code_q <= mode_wdata[2:0];
            end
        end
    end

    p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
        mode_wr |-> (mode_wdata[2:0] inside {3'b000, 3'b001, 3'b011, 3'b010, 3'b100}));

    p_lock_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_wr || refr_wr) |-> (since_q >= GW'(LOCK_CYC - 1)));

    p_up_via_half_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && last_code_q == 3'b000) |-> (mode_wdata[2:0] == 3'b001));

    p_down_via_half_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && last_code_q inside {3'b011, 3'b010, 3'b100}) |-> (mode_wdata[2:0] != 3'b000));

    p_keep_upper_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && !req_ack) |-> (mode_wdata[MODE_W-1:3] == hi_q));

    p_no_ack_busy_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ack);

    p_err_excl_r11: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (!req_ack && !busy));

    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mode_wr && !refr_wr));

    p_one_write: assert property (@(posedge clk) disable iff (rst)
        !(mode_wr && refr_wr));
endmodule

bind div_seq_top div_seq_chk #(.MODE_W(MODE_W), .LOCK_CYC(LOCK_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ack    (req_ack),
    .req_err    (req_err),
    .cur_mode   (cur_mode),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .refr_wr    (refr_wr),
    .busy       (busy)
);

// File: tb/div_seq_top_tb.sv
module div_seq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MODE_W = 16;
    localparam int REFR_W = 7;
    localparam int BASE   = 12;
    localparam int CLKS   = 64;
    localparam logic [MODE_W-1:0] MODE0 = 16'hB7C8;

    logic clk = 0, rst = 1;
    logic req_valid = 0, self_refresh = 0;
    logic [2:0] req_index = 0;
    logic req_ack, req_err, mode_wr, refr_wr, busy;
    logic [MODE_W-1:0] mode_wdata, mode_q;
    logic [REFR_W-1:0] refr_val;

    int errors = 0, checks = 0;
    int q_kind[$], q_val[$], q_min[$], q_max[$], q_req[$];
    int nmin, nmax, model_div, cyc, last_cyc;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    div_seq_top u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
        .req_ack(req_ack), .req_err(req_err), .cur_mode(mode_q),
        .self_refresh(self_refresh), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .refr_wr(refr_wr), .refr_val(refr_val), .busy(busy)
    );

    always @(posedge clk) begin
        if (rst) mode_q <= MODE0;
        else if (mode_wr) mode_q <= mode_wdata;
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int code(input int d);
        case (d)
            1: return 0; 2: return 1; 4: return 3; 6: return 2; 8: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int div_of_idx(input int i);
        case (i)
            0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 8;
        endcase
    endfunction

    task automatic push(input int kind, input int val, input int rq);
        q_kind.push_back(kind); q_val.push_back(val);
        q_min.push_back(nmin);  q_max.push_back(nmax);
        q_req.push_back(rq);
    endtask

    task automatic push_hop(input int a, input int b, input int rq);
        int mval;
        mval = int'({MODE0[MODE_W-1:3], 3'(code(b))});
        if (b > a) begin
            push(1, BASE / b, rq);
            if (a == 1 && b == 2 && !self_refresh) begin
                nmin = CLKS * (BASE + BASE / 2); nmax = nmin + 4;
            end else begin
                nmin = 1; nmax = 4;
            end
            push(0, mval, rq);
            nmin = 16; nmax = 20;
        end else begin
            push(0, mval, rq);
            nmin = 16; nmax = 20;
            push(1, BASE / b, rq);
            nmin = 1; nmax = 6;
        end
    endtask

    task automatic plan_move(input int to, input int rq);
        int from;
        from = model_div;
        nmin = 0; nmax = 1000000;
        if (from == 1 && to > 2) begin
            push_hop(1, 2, rq); push_hop(2, to, rq);
        end else if (from > 2 && to == 1) begin
            push_hop(from, 2, rq); push_hop(2, 1, rq);
        end else if (from != to) begin
            push_hop(from, to, rq);
        end
        model_div = to;
    endtask

    task automatic issue(input int idx, output bit got_ack, output bit got_err, output int waited);
        waited = 0;
        @(negedge clk);
        req_valid = 1; req_index = 3'(idx);
        forever begin
            #1;
            if (req_ack || req_err) break;
            @(negedge clk);
            waited++;
        end
        got_ack = req_ack; got_err = req_err;
        check(!(req_ack && busy), "R10 ack while busy", int'(busy), 0);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_idle(input string rq);
        int n = 0;
        while ((busy || q_kind.size() != 0) && n < 5000) begin
            @(negedge clk); n++;
        end
        repeat (3) @(negedge clk);
        check(q_kind.size() == 0, rq, q_kind.size(), 0);
    endtask

    task automatic move(input int idx, input int rq, input string tag);
        bit a, e; int w;
        plan_move(div_of_idx(idx), rq);
        issue(idx, a, e, w);
        check(a && !e, tag, int'(a), 1);
        wait_idle(tag);
    endtask

    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; last_cyc = 0;
        end else begin
            cyc++;
            if (mode_wr || refr_wr) begin
                if (q_kind.size() == 0) begin
                    check(0, "R8/R11 unexpected write", int'(mode_wr ? mode_wdata : refr_val), -1);
                end else begin
                    int k, v, mn, mx, rq, gap, act;
                    k = q_kind.pop_front(); v = q_val.pop_front();
                    mn = q_min.pop_front(); mx = q_max.pop_front(); rq = q_req.pop_front();
                    act = mode_wr ? int'(mode_wdata) : int'(refr_val);
                    gap = cyc - last_cyc;
                    check(k == (refr_wr ? 1 : 0), $sformatf("R%0d write kind", rq), int'(refr_wr), k);
                    check(act == v, $sformatf("R%0d write value (R1 R9 R12)", rq), act, v);
                    check(gap >= mn && gap <= mx, $sformatf("R%0d gap (R2 R7)", rq), gap, mn);
                end
                last_cyc = cyc;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        bit a, e; int w, w2;
        model_div = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check(!busy && !mode_wr && !refr_wr && !req_ack, "reset state", int'(busy), 0);

        move(1, 7, "R7 drain on 1->2");            // R6 R7
        move(0, 5, "R5 2->1");                      // R5
        move(3, 3, "R3 1->6 via 2");                // R3
        move(4, 6, "R6 6->8 slowing");              // R6
        move(2, 5, "R5 8->4 speeding");             // R5
        move(0, 4, "R4 4->1 via 2");                // R4
        move(0, 8, "R8 same ratio");                // R8

        issue(5, a, e, w);
        check(e && !a, "R11 index 5", int'(e), 1);
        issue(7, a, e, w);
        check(e && !a, "R11 index 7", int'(e), 1);
        wait_idle("R11 no writes");

        self_refresh = 1;
        move(1, 7, "R7 no drain in self-refresh"); // R7

        // R10: second request raised while the first sequence runs
        plan_move(8, 6);
        issue(4, a, e, w);
        check(a, "R10 first accepted", int'(a), 1);
        plan_move(1, 4);
        issue(0, a, e, w2);
        check(a && w2 >= 5, "R10 second held off", w2, 5);
        wait_idle("R10 sequence done");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule